// File: doc/BRIEF.md
# Hardware System Stack Controller

This block is the return stack of a DSP program sequencer. It keeps fifteen 32-bit entries. Each entry is held as two 16-bit halves in two separate banks, an upper bank and a lower bank. A subroutine call or long interrupt saves the program counter in the upper half and the status register in the lower half. A hardware loop start saves two entries: first the loop address and loop count, then the program counter and status register.

The sequencer never gives an address. The block works only on its top entry, and the command picks what is stored or restored. A subroutine return gives back the program counter and leaves the status register alone. An interrupt return gives back both. A loop-end pop takes two cycles. The first cycle brings back the program counter and status register. The second cycle brings back the loop address and loop count. Each restored value comes with its own valid strobe.

The stack pointer, a sticky overflow flag and a sticky underflow flag are visible at the ports.

Top module: `sys_stack_ctl`

## Requirements
- R1: While reset is held, and in the first cycle after it, the stack pointer is 0. Both flags, all strobes, `busy_o` and all four restored-value outputs are 0.
- R2: A call push with fewer than 15 entries stored writes `pc_i` to the upper half and `sr_i` to the lower half of a new top entry, and raises the stack pointer by one in the next cycle.
- R3: A subroutine return with a non-empty stack puts the top upper half on `pc_o` and pulses `pc_vld_o` in the next cycle. `sr_vld_o` stays low, `sr_o` keeps its old value, and the pointer drops by one.
- R4: An interrupt return with a non-empty stack puts the top upper half on `pc_o` and the top lower half on `sr_o`. It pulses both `pc_vld_o` and `sr_vld_o`, and the pointer drops by one.
- R5: A loop push with at most 13 entries stored writes `{la_i,lc_i}` at the current top and `{pc_i,sr_i}` above it in a single cycle. The pointer rises by two.
- R6: A loop pop with at least 2 entries stored takes two cycles. In the first cycle after the command, PC:SR comes out with `pc_vld_o`, `sr_vld_o` and `busy_o` high. In the next cycle, LA:LC comes out on `la_o`/`lc_o` with `loop_vld_o` high and `busy_o` low. Each of the two cycles lowers the pointer by one.
- R7: Any command presented while `busy_o` is high is ignored. Only the pending second step of the loop pop runs in that cycle.
- R8: When several commands are asserted together, exactly one is executed. The order of priority is interrupt return, subroutine return, loop pop, call push, loop push.
- R9: A call push with 15 entries stored, or a loop push with more than 13 stored, sets `ovf_o`. The pointer and the stored contents do not change. `ovf_o` stays set until reset.
- R10: A subroutine or interrupt return on an empty stack sets `unf_o`. The usual strobes still pulse, with zero data. A loop pop with fewer than 2 entries sets `unf_o`, pulses no strobe and leaves the pointer unchanged. `unf_o` stays set until reset.
- R11: Entries come back in last-in first-out order across any mix of pushes and pops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| call_push_i | input | 1 | Save PC:SR for a call or long interrupt |
| loop_push_i | input | 1 | Save LA:LC, then PC:SR, for a loop start |
| sub_ret_i | input | 1 | Subroutine return (PC only) |
| int_ret_i | input | 1 | Interrupt return (PC and SR) |
| loop_pop_i | input | 1 | Loop end, two-step pop |
| pc_i | input | 16 | Program counter to save |
| sr_i | input | 16 | Status register to save |
| la_i | input | 16 | Loop address to save |
| lc_i | input | 16 | Loop count to save |
| pc_o | output | 16 | Restored program counter |
| sr_o | output | 16 | Restored status register |
| la_o | output | 16 | Restored loop address |
| lc_o | output | 16 | Restored loop count |
| pc_vld_o | output | 1 | `pc_o` updated this cycle |
| sr_vld_o | output | 1 | `sr_o` updated this cycle |
| loop_vld_o | output | 1 | `la_o`/`lc_o` updated this cycle |
| busy_o | output | 1 | Second step of a loop pop is pending |
| sp_o | output | 4 | Number of entries stored |
| ovf_o | output | 1 | Sticky overflow |
| unf_o | output | 1 | Sticky underflow |

## Verification
A wrong pointer shows up on `sp_o` in the same cycle. It also shows up later as wrong data on the next pop, because the read and write positions follow from the pointer. A corrupted bank entry stays hidden until that entry reaches the top and is popped. For that reason the bench pops every value it pushes and checks the order of return. A stuck two-step state shows at once on `busy_o` and as a missing `loop_vld_o` one cycle later. The reference model is compared on every clock, so the first wrong cycle is reported.

// File: rtl/sys_stack_pkg.sv
package sys_stack_pkg;
    // Operation chosen for the current cycle
    typedef enum logic [2:0] {
        OP_IDLE,
        OP_INT_RET,
        OP_SUB_RET,
        OP_LOOP_POP,
        OP_CALL,
        OP_LOOP_PUSH,
        OP_LOOP_FIN
    } stk_op_e;
endpackage

// File: rtl/ss_cmd_arb.sv
// Fixed-priority selection of one command per cycle
module ss_cmd_arb
    import sys_stack_pkg::*;
(
    input  logic    busy,
    input  logic    int_ret,
    input  logic    sub_ret,
    input  logic    loop_pop,
    input  logic    call_push,
    input  logic    loop_push,
    output stk_op_e op
);
    always_comb begin
        if (busy)           op = OP_LOOP_FIN;
        else if (int_ret)   op = OP_INT_RET;
        else if (sub_ret)   op = OP_SUB_RET;
        else if (loop_pop)  op = OP_LOOP_POP;
        else if (call_push) op = OP_CALL;
        else if (loop_push) op = OP_LOOP_PUSH;
        else                op = OP_IDLE;
    end
endmodule

// File: rtl/ss_bank.sv
// One half-width bank: two write ports, one asynchronous read port
module ss_bank #(
    parameter int DEPTH = 15,
    parameter int W     = 16,
    parameter int AW    = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_a,
    input  logic [AW-1:0] wa_a,
    input  logic [W-1:0]  wd_a,
    input  logic          we_b,
    input  logic [AW-1:0] wa_b,
    input  logic [W-1:0]  wd_b,
    input  logic [AW-1:0] ra,
    output logic [W-1:0]  rd
);
    logic [DEPTH-1:0][W-1:0] mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        for (int i = 0; i < DEPTH; i++) begin
            if (we_a && wa_a == AW'(i)) mem_d[i] = wd_a;
            if (we_b && wa_b == AW'(i)) mem_d[i] = wd_b;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mem_q <= '0;
        else        mem_q <= mem_d;
    end

    always_comb begin
        rd = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (ra == AW'(i)) rd = mem_q[i];
        end
    end
endmodule

// File: rtl/sys_stack_ctl.sv
module sys_stack_ctl
    import sys_stack_pkg::*;
#(
    parameter int DEPTH = 15,
    parameter int W     = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         call_push_i,
    input  logic                         loop_push_i,
    input  logic                         sub_ret_i,
    input  logic                         int_ret_i,
    input  logic                         loop_pop_i,
    input  logic [W-1:0]                 pc_i,
    input  logic [W-1:0]                 sr_i,
    input  logic [W-1:0]                 la_i,
    input  logic [W-1:0]                 lc_i,
    output logic [W-1:0]                 pc_o,
    output logic [W-1:0]                 sr_o,
    output logic [W-1:0]                 la_o,
    output logic [W-1:0]                 lc_o,
    output logic                         pc_vld_o,
    output logic                         sr_vld_o,
    output logic                         loop_vld_o,
    output logic                         busy_o,
    output logic [$clog2(DEPTH+1)-1:0]   sp_o,
    output logic                         ovf_o,
    output logic                         unf_o
);
    localparam int PW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] SP_FULL = PW'(DEPTH);
    localparam logic [PW-1:0] SP_PAIR = PW'(DEPTH - 2);
    localparam logic [PW-1:0] SP_ONE  = PW'(1);

    typedef struct packed {
        logic [PW-1:0] sp;
        logic          ovf;
        logic          unf;
        logic          busy;
        logic          pcv;
        logic          srv;
        logic          lv;
        logic [W-1:0]  pc;
        logic [W-1:0]  sr;
        logic [W-1:0]  la;
        logic [W-1:0]  lc;
    } ctl_t;

    ctl_t    st_d, st_q;
    stk_op_e op;

    logic          we_a, we_b;
    logic [PW-1:0] wa_a, wa_b, top_idx;
    logic [W-1:0]  hi_wd_a, lo_wd_a, hi_wd_b, lo_wd_b;
    logic [W-1:0]  hi_rd, lo_rd;

    ss_cmd_arb u_arb (
        .busy      (st_q.busy),
        .int_ret   (int_ret_i),
        .sub_ret   (sub_ret_i),
        .loop_pop  (loop_pop_i),
        .call_push (call_push_i),
        .loop_push (loop_push_i),
        .op        (op)
    );

    ss_bank #(.DEPTH(DEPTH), .W(W), .AW(PW)) u_hi_bank (
        .clk (clk), .rst_n (rst_n),
        .we_a (we_a), .wa_a (wa_a), .wd_a (hi_wd_a),
        .we_b (we_b), .wa_b (wa_b), .wd_b (hi_wd_b),
        .ra (top_idx), .rd (hi_rd)
    );

    ss_bank #(.DEPTH(DEPTH), .W(W), .AW(PW)) u_lo_bank (
        .clk (clk), .rst_n (rst_n),
        .we_a (we_a), .wa_a (wa_a), .wd_a (lo_wd_a),
        .we_b (we_b), .wa_b (wa_b), .wd_b (lo_wd_b),
        .ra (top_idx), .rd (lo_rd)
    );

    // Write position and data: a loop push places LA:LC at the current
    // top and PC:SR one slot above it; a call places PC:SR at the top.
    assign top_idx = st_q.sp - SP_ONE;
    assign wa_a    = st_q.sp;
    assign wa_b    = st_q.sp + SP_ONE;
    assign hi_wd_a = (op == OP_LOOP_PUSH) ? la_i : pc_i;
    assign lo_wd_a = (op == OP_LOOP_PUSH) ? lc_i : sr_i;
    assign hi_wd_b = pc_i;
    assign lo_wd_b = sr_i;

    always_comb begin
        st_d     = st_q;
        st_d.pcv = 1'b0;
        st_d.srv = 1'b0;
        st_d.lv  = 1'b0;
        we_a     = 1'b0;
        we_b     = 1'b0;
        unique case (op)
            OP_LOOP_FIN: begin
                st_d.la   = hi_rd;
                st_d.lc   = lo_rd;
                st_d.lv   = 1'b1;
                st_d.busy = 1'b0;
                st_d.sp   = st_q.sp - SP_ONE;
            end
            OP_INT_RET: begin
                st_d.pcv = 1'b1;
                st_d.srv = 1'b1;
                if (st_q.sp == '0) begin
                    st_d.unf = 1'b1;
                    st_d.pc  = '0;
                    st_d.sr  = '0;
                end else begin
                    st_d.pc = hi_rd;
                    st_d.sr = lo_rd;
                    st_d.sp = st_q.sp - SP_ONE;
                end
            end
            OP_SUB_RET: begin
                st_d.pcv = 1'b1;
                if (st_q.sp == '0) begin
                    st_d.unf = 1'b1;
                    st_d.pc  = '0;
                end else begin
                    st_d.pc = hi_rd;
                    st_d.sp = st_q.sp - SP_ONE;
                end
            end
            OP_LOOP_POP: begin
                if (st_q.sp <= SP_ONE) begin
                    st_d.unf = 1'b1;
                end else begin
                    st_d.pc   = hi_rd;
                    st_d.sr   = lo_rd;
                    st_d.pcv  = 1'b1;
                    st_d.srv  = 1'b1;
                    st_d.busy = 1'b1;
                    st_d.sp   = st_q.sp - SP_ONE;
                end
            end
            OP_CALL: begin
                if (st_q.sp == SP_FULL) begin
                    st_d.ovf = 1'b1;
                end else begin
                    we_a    = 1'b1;
                    st_d.sp = st_q.sp + SP_ONE;
                end
            end
            OP_LOOP_PUSH: begin
                if (st_q.sp > SP_PAIR) begin
                    st_d.ovf = 1'b1;
                end else begin
                    we_a    = 1'b1;
                    we_b    = 1'b1;
                    st_d.sp = st_q.sp + PW'(2);
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pc_o       = st_q.pc;
    assign sr_o       = st_q.sr;
    assign la_o       = st_q.la;
    assign lc_o       = st_q.lc;
    assign pc_vld_o   = st_q.pcv;
    assign sr_vld_o   = st_q.srv;
    assign loop_vld_o = st_q.lv;
    assign busy_o     = st_q.busy;
    assign sp_o       = st_q.sp;
    assign ovf_o      = st_q.ovf;
    assign unf_o      = st_q.unf;
endmodule

// File: rtl/ss_chk.sv
module ss_chk #(
    parameter int PW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          call_push_i,
    input logic          sub_ret_i,
    input logic          int_ret_i,
    input logic          loop_pop_i,
    input logic          pc_vld_o,
    input logic          sr_vld_o,
    input logic          loop_vld_o,
    input logic          busy_o,
    input logic [PW-1:0] sp_o,
    input logic          ovf_o,
    input logic          unf_o
);
    // R9
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |=> ovf_o);

    // R10
    unf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unf_o |=> unf_o);

    // R6
    loop_second_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> (loop_vld_o && !busy_o && !pc_vld_o));

    // R7
    busy_ignores_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && call_push_i) |=> (sp_o == $past(sp_o) - PW'(1)));

    // R3
    sub_ret_keeps_sr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sub_ret_i && !int_ret_i && !busy_o) |=> (pc_vld_o && !sr_vld_o));

    // R4
    int_ret_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int_ret_i && !busy_o) |=> (pc_vld_o && sr_vld_o));

    // R8
    int_ret_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int_ret_i && sub_ret_i && loop_pop_i && !busy_o) |=> (sr_vld_o && !busy_o));

    // R2
    call_grows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (call_push_i && !int_ret_i && !sub_ret_i && !loop_pop_i && !busy_o
         && sp_o != PW'(15)) |=> (sp_o == $past(sp_o) + PW'(1)));
endmodule

bind sys_stack_ctl ss_chk #(.PW(PW)) u_ss_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .call_push_i (call_push_i),
    .sub_ret_i   (sub_ret_i),
    .int_ret_i   (int_ret_i),
    .loop_pop_i  (loop_pop_i),
    .pc_vld_o    (pc_vld_o),
    .sr_vld_o    (sr_vld_o),
    .loop_vld_o  (loop_vld_o),
    .busy_o      (busy_o),
    .sp_o        (sp_o),
    .ovf_o       (ovf_o),
    .unf_o       (unf_o)
);

// File: tb/tb_sys_stack_ctl.sv
module tb_sys_stack_ctl;
    localparam int CLK_PERIOD = 10;

    localparam logic [4:0] C_NONE  = 5'b00000;
    localparam logic [4:0] C_CALL  = 5'b00001;
    localparam logic [4:0] C_LPUSH = 5'b00010;
    localparam logic [4:0] C_RTS   = 5'b00100;
    localparam logic [4:0] C_RTI   = 5'b01000;
    localparam logic [4:0] C_LPOP  = 5'b10000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic call_push_i = 0, loop_push_i = 0, sub_ret_i = 0, int_ret_i = 0, loop_pop_i = 0;
    logic [15:0] pc_i = 0, sr_i = 0, la_i = 0, lc_i = 0;
    logic [15:0] pc_o, sr_o, la_o, lc_o;
    logic pc_vld_o, sr_vld_o, loop_vld_o, busy_o, ovf_o, unf_o;
    logic [3:0] sp_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model state
    logic [31:0] q[$];
    logic [15:0] m_pc, m_sr, m_la, m_lc;
    bit m_pcv, m_srv, m_lv, m_busy, m_ovf, m_unf;

    always #(CLK_PERIOD/2) clk = ~clk;

    sys_stack_ctl dut (
        .clk (clk), .rst_n (rst_n),
        .call_push_i (call_push_i), .loop_push_i (loop_push_i),
        .sub_ret_i (sub_ret_i), .int_ret_i (int_ret_i), .loop_pop_i (loop_pop_i),
        .pc_i (pc_i), .sr_i (sr_i), .la_i (la_i), .lc_i (lc_i),
        .pc_o (pc_o), .sr_o (sr_o), .la_o (la_o), .lc_o (lc_o),
        .pc_vld_o (pc_vld_o), .sr_vld_o (sr_vld_o), .loop_vld_o (loop_vld_o),
        .busy_o (busy_o), .sp_o (sp_o), .ovf_o (ovf_o), .unf_o (unf_o)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic compare(input string tag);
        chk(tag, "sp", int'(sp_o), q.size());
        chk(tag, "ovf", int'(ovf_o), int'(m_ovf));
        chk(tag, "unf", int'(unf_o), int'(m_unf));
        chk(tag, "busy", int'(busy_o), int'(m_busy));
        chk(tag, "pc_vld", int'(pc_vld_o), int'(m_pcv));
        chk(tag, "sr_vld", int'(sr_vld_o), int'(m_srv));
        chk(tag, "loop_vld", int'(loop_vld_o), int'(m_lv));
        chk(tag, "pc", int'(pc_o), int'(m_pc));
        chk(tag, "sr", int'(sr_o), int'(m_sr));
        chk(tag, "la", int'(la_o), int'(m_la));
        chk(tag, "lc", int'(lc_o), int'(m_lc));
    endtask

    task automatic model_clear();
        q.delete();
        m_pc = 0; m_sr = 0; m_la = 0; m_lc = 0;
        m_pcv = 0; m_srv = 0; m_lv = 0; m_busy = 0; m_ovf = 0; m_unf = 0;
    endtask

    task automatic model_update(input logic [4:0] c, input logic [15:0] pc, sr, la, lc);
        logic [31:0] e;
        m_pcv = 0; m_srv = 0; m_lv = 0;
        if (m_busy) begin
            e = q.pop_back();
            m_la = e[31:16]; m_lc = e[15:0]; m_lv = 1; m_busy = 0;
        end else if (c[3]) begin
            m_pcv = 1; m_srv = 1;
            if (q.size() == 0) begin m_unf = 1; m_pc = 0; m_sr = 0; end
            else begin e = q.pop_back(); m_pc = e[31:16]; m_sr = e[15:0]; end
        end else if (c[2]) begin
            m_pcv = 1;
            if (q.size() == 0) begin m_unf = 1; m_pc = 0; end
            else begin e = q.pop_back(); m_pc = e[31:16]; end
        end else if (c[4]) begin
            if (q.size() < 2) m_unf = 1;
            else begin
                e = q.pop_back(); m_pc = e[31:16]; m_sr = e[15:0];
                m_pcv = 1; m_srv = 1; m_busy = 1;
            end
        end else if (c[0]) begin
            if (q.size() >= 15) m_ovf = 1;
            else q.push_back({pc, sr});
        end else if (c[1]) begin
            if (q.size() > 13) m_ovf = 1;
            else begin q.push_back({la, lc}); q.push_back({pc, sr}); end
        end
    endtask

    // inputs change at the falling edge; outputs are sampled 1 time unit after the rising edge
    task automatic step(input string tag, input logic [4:0] c,
                        input logic [15:0] pc, sr, la, lc);
        {loop_pop_i, int_ret_i, sub_ret_i, loop_push_i, call_push_i} = c;
        pc_i = pc; sr_i = sr; la_i = la; lc_i = lc;
        @(posedge clk);
        #1;
        model_update(c, pc, sr, la, lc);
        compare(tag);
        @(negedge clk);
    endtask

    task automatic do_reset();
        {loop_pop_i, int_ret_i, sub_ret_i, loop_push_i, call_push_i} = C_NONE;
        rst_n = 0;
        model_clear();
        repeat (2) @(negedge clk);
        compare("R1");
        rst_n = 1;
        step("R1", C_NONE, 0, 0, 0, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: run hung (R11), actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        model_clear();
        @(negedge clk);
        do_reset();

        // R2 / R3 / R4: call pushes and both kinds of return
        step("R2", C_CALL, 16'h1111, 16'hA001, 0, 0);
        step("R2", C_CALL, 16'h2222, 16'hA002, 0, 0);
        step("R2", C_CALL, 16'h3333, 16'hA003, 0, 0);
        step("R4", C_RTI, 0, 0, 0, 0);
        step("R3", C_RTS, 0, 0, 0, 0);
        step("R3", C_NONE, 0, 0, 0, 0);
        step("R4", C_RTI, 0, 0, 0, 0);

        // R5 / R6 / R7: loop push, a nested call, then a loop pop with a command while busy
        step("R5", C_LPUSH, 16'h0400, 16'h5000, 16'h0480, 16'h0010);
        step("R5", C_CALL, 16'h0410, 16'h5001, 0, 0);
        step("R3", C_RTS, 0, 0, 0, 0);
        step("R6", C_LPOP, 0, 0, 0, 0);
        step("R7", C_CALL | C_RTI, 16'hDEAD, 16'hBEEF, 0, 0);
        step("R6", C_NONE, 0, 0, 0, 0);
        step("R5", C_LPUSH, 16'h0500, 16'h5100, 16'h0580, 16'h0020);
        step("R5", C_LPUSH, 16'h0600, 16'h5200, 16'h0680, 16'h0030);
        step("R6", C_LPOP, 0, 0, 0, 0);
        step("R6", C_NONE, 0, 0, 0, 0);
        step("R6", C_LPOP, 0, 0, 0, 0);
        step("R7", C_LPUSH, 16'h0700, 16'h5300, 16'h0780, 16'h0040);

        // R8: several commands at once
        step("R8", C_CALL, 16'h0A0A, 16'h0B0B, 0, 0);
        step("R8", C_CALL, 16'h0C0C, 16'h0D0D, 0, 0);
        step("R8", C_CALL, 16'h0E0E, 16'h0F0F, 0, 0);
        step("R8", C_RTI | C_RTS | C_LPOP | C_CALL | C_LPUSH, 16'h9999, 16'h9999, 16'h9999, 16'h9999);
        step("R8", C_RTS | C_LPOP | C_CALL | C_LPUSH, 16'h8888, 16'h8888, 16'h8888, 16'h8888);
        step("R8", C_LPOP | C_CALL | C_LPUSH, 16'h7777, 16'h7777, 16'h7777, 16'h7777);
        step("R8", C_NONE, 0, 0, 0, 0);
        step("R8", C_CALL | C_LPUSH, 16'h6666, 16'h6661, 16'h6662, 16'h6663);
        step("R8", C_RTI, 0, 0, 0, 0);

        // R10: underflow on an empty stack and a loop pop with a single entry
        do_reset();
        step("R10", C_CALL, 16'h1234, 16'h5678, 0, 0);
        step("R10", C_LPOP, 0, 0, 0, 0);
        step("R10", C_RTI, 0, 0, 0, 0);
        step("R10", C_RTS, 0, 0, 0, 0);
        step("R10", C_RTI, 0, 0, 0, 0);
        step("R10", C_CALL, 16'h4321, 16'h8765, 0, 0);
        step("R10", C_RTI, 0, 0, 0, 0);

        // R9: fill to 15, try both kinds of push, then drain and verify contents
        do_reset();
        for (int i = 0; i < 13; i++) step("R9", C_CALL, 16'(i + 16'h100), 16'(i + 16'h200), 0, 0);
        step("R9", C_CALL, 16'h0D0D, 16'h0D0D, 0, 0);
        step("R9", C_LPUSH, 16'hEEEE, 16'hEEEE, 16'hEEEE, 16'hEEEE);
        step("R9", C_CALL, 16'h0E0E, 16'h0E0E, 0, 0);
        step("R9", C_CALL, 16'hFFFF, 16'hFFFF, 0, 0);
        for (int i = 0; i < 15; i++) step("R9", C_RTI, 0, 0, 0, 0);

        // R5 boundary: loop push with exactly 13 entries fits
        do_reset();
        for (int i = 0; i < 13; i++) step("R5", C_CALL, 16'(i), 16'(i + 1), 0, 0);
        step("R5", C_LPUSH, 16'hAB01, 16'hAB02, 16'hAB03, 16'hAB04);
        step("R6", C_LPOP, 0, 0, 0, 0);
        step("R6", C_NONE, 0, 0, 0, 0);

        // R11: long pseudo-random mix checked against the model
        do_reset();
        lfsr = 16'hACE1;
        for (int n = 0; n < 600; n++) begin
            logic [4:0] c;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            case (lfsr[2:0])
                3'd0, 3'd1: c = C_CALL;
                3'd2:       c = C_LPUSH;
                3'd3:       c = C_RTS;
                3'd4:       c = C_RTI;
                3'd5:       c = C_LPOP;
                3'd6:       c = lfsr[7:3];
                default:    c = C_NONE;
            endcase
            step("R11", c, lfsr, ~lfsr, lfsr ^ 16'h5A5A, {lfsr[7:0], lfsr[15:8]});
            if (n % 150 == 149) do_reset();
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule